// File: doc/BRIEF.md
# Next Program Counter Generator

This block produces the address of the next instruction for a processor with fixed 32-bit instructions at byte addresses. It owns the program counter register. Each cycle it forms three candidate addresses from the current value. The first is the sequential address four bytes on. The second is a conditional-branch target: a signed word displacement taken from the instruction is added to the sequential address. The third is a pseudo-direct jump target: a 26-bit word index from the instruction is joined to the top four bits of the sequential address.

The decode stage marks the instruction as a conditional branch or a direct jump. The comparator supplies a taken flag. The block picks the jump first, then a taken branch, and otherwise the sequential address. The result appears combinationally on `next_pc` and is loaded into the program counter on the next rising edge unless `stall` is high. Register-indirect jumps, exceptions and fetch belong to other blocks.

Top module: `npc_gen`

## Requirements
- R1: While `rst_n` is low, `pc_q` equals the parameter `RESET_PC` (default 0x0040_0000).
- R2: A rising edge with `stall` high leaves `pc_q` unchanged. A rising edge with `stall` low loads `pc_q` from the `next_pc` that was present before the edge.
- R3: When neither `is_jump` nor `is_branch` is set, `next_pc` equals `pc_q + 4`.
- R4: When `is_branch` and `br_taken` are both high and `is_jump` is low, `next_pc` equals `pc_q + 4 + 4*imm`. Here imm is `instr[15:0]` read as a two's-complement number.
- R5: A branch immediate with bit 15 set moves the target backward, down to -131072 bytes for immediate 0x8000.
- R6: A branch with `br_taken` low gives `next_pc = pc_q + 4`.
- R7: `br_taken` high without `is_branch` has no effect: `next_pc = pc_q + 4`.
- R8: When `is_jump` is high, `next_pc` is bits 31..28 of `pc_q + 4`, then `instr[25:0]`, then two zero bits.
- R9: `is_jump` overrides a simultaneous taken branch.
- R10: The jump's top four bits come from `pc_q + 4`. A jump at 0x0FFF_FFFC therefore lands in the region starting at 0x1000_0000.
- R11: `pc_q[1:0]` is always zero when `RESET_PC` is word aligned.
- R12: The sequential address wraps modulo 2^32, so 0xFFFF_FFFC is followed by 0x0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the program counter |
| stall | input | 1 | Holds the program counter when high |
| instr | input | 32 | Instruction word being executed |
| is_branch | input | 1 | Instruction is a conditional branch |
| is_jump | input | 1 | Instruction is a direct jump |
| br_taken | input | 1 | Branch condition result from the comparator |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address to be loaded on the next unstalled edge |

## Verification
The checker watches several rules every cycle. It checks the target arithmetic of each kind of transfer against the port values: the sign-extended offset is recovered as the difference between `next_pc` and the sequential address, and the jump's region and index fields are compared directly. It also checks that the jump wins, that `stall` holds the register, that an unstalled edge loads `next_pc`, that the low bits stay zero, and that the reset value is right. Some outcomes need chosen addresses and immediates, and only the bench's scenarios show them: the most negative displacement, a jump from the last word of a 256 MB region, and the wrap from the top of the address space (seen through a second instance reset near 0xFFFF_FFFC).

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int PC_W     = 32;
  localparam int INSTR_W  = 32;
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
  localparam int ALIGN_W  = 2;
  localparam int REGION_W = PC_W - JIDX_W - ALIGN_W;
  localparam int EXT_W    = PC_W - ALIGN_W - IMM_W;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [IMM_W-1:0]  imm_t;
  typedef logic [JIDX_W-1:0] jidx_t;

  localparam pc_t STEP = pc_t'(1) << ALIGN_W;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } src_e;

  // Sequential address: one instruction word further on.
  function automatic pc_t seq_addr(pc_t pc);
    return pc + STEP;
  endfunction

  // Sign-extended word displacement added to the sequential address.
  function automatic pc_t branch_addr(pc_t seq, imm_t imm);
    pc_t offset;
    offset = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    return seq + offset;
  endfunction

  // Region bits of the sequential address joined to the word index.
  function automatic pc_t jump_addr(pc_t seq, jidx_t idx);
    return {seq[PC_W-1 -: REGION_W], idx, {ALIGN_W{1'b0}}};
  endfunction

  // Jump first, then a taken branch, otherwise fall through.
  function automatic src_e pick_src(logic jmp, logic br, logic taken);
    if (jmp)             return SRC_JUMP;
    else if (br && taken) return SRC_BRANCH;
    else                 return SRC_SEQ;
  endfunction

endpackage

// File: rtl/npc_seq_adder.sv
module npc_seq_adder
  import npc_pkg::*;
(
  input  pc_t pc_i,
  output pc_t seq_o
);
  assign seq_o = seq_addr(pc_i);
endmodule

// File: rtl/npc_branch_target.sv
module npc_branch_target
  import npc_pkg::*;
(
  input  pc_t  seq_i,
  input  imm_t imm_i,
  output pc_t  tgt_o
);
  assign tgt_o = branch_addr(seq_i, imm_i);
endmodule

// File: rtl/npc_jump_target.sv
module npc_jump_target
  import npc_pkg::*;
(
  input  pc_t   seq_i,
  input  jidx_t idx_i,
  output pc_t   tgt_o
);
  assign tgt_o = jump_addr(seq_i, idx_i);
endmodule

// File: rtl/npc_src_mux.sv
module npc_src_mux
  import npc_pkg::*;
(
  input  logic is_jump_i,
  input  logic is_branch_i,
  input  logic br_taken_i,
  input  pc_t  seq_i,
  input  pc_t  br_i,
  input  pc_t  jmp_i,
  output src_e src_o,
  output pc_t  next_o
);
  always_comb begin
    src_o = pick_src(is_jump_i, is_branch_i, br_taken_i);
    unique case (src_o)
      SRC_JUMP:   next_o = jmp_i;
      SRC_BRANCH: next_o = br_i;
      default:    next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
  import npc_pkg::*;
#(
  parameter pc_t RESET_PC = 32'h0040_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall,
  input  logic [INSTR_W-1:0] instr,
  input  logic               is_branch,
  input  logic               is_jump,
  input  logic               br_taken,
  output logic [PC_W-1:0]    pc_q,
  output logic [PC_W-1:0]    next_pc
);

  // Named internal events, visible to the bound checker.
  pc_t  seq_pc;
  pc_t  br_pc;
  pc_t  jmp_pc;
  src_e src;

  imm_t  imm_field;
  jidx_t idx_field;
  logic  unused_opcode;

  assign imm_field     = instr[IMM_W-1:0];
  assign idx_field     = instr[JIDX_W-1:0];
  assign unused_opcode = ^instr[INSTR_W-1:JIDX_W];

  npc_seq_adder u_seq (
    .pc_i  (pc_q),
    .seq_o (seq_pc)
  );

  npc_branch_target u_br (
    .seq_i (seq_pc),
    .imm_i (imm_field),
    .tgt_o (br_pc)
  );

  npc_jump_target u_jmp (
    .seq_i (seq_pc),
    .idx_i (idx_field),
    .tgt_o (jmp_pc)
  );

  npc_src_mux u_mux (
    .is_jump_i   (is_jump),
    .is_branch_i (is_branch),
    .br_taken_i  (br_taken),
    .seq_i       (seq_pc),
    .br_i        (br_pc),
    .jmp_i       (jmp_pc),
    .src_o       (src),
    .next_o      (next_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= RESET_PC;
    else if (!stall) pc_q <= next_pc;
  end

endmodule

// File: rtl/npc_gen_chk.sv
module npc_gen_chk
  import npc_pkg::*;
#(
  parameter pc_t RESET_PC = 32'h0040_0000
) (
  input logic  clk,
  input logic  rst_n,
  input logic  stall,
  input logic  is_branch,
  input logic  is_jump,
  input logic  br_taken,
  input jidx_t field,
  input pc_t   pc_q,
  input pc_t   next_pc,
  input pc_t   seq_pc,
  input src_e  src
);

  localparam int OFF_W = IMM_W + ALIGN_W;

  logic signed [OFF_W-1:0] off_s;
  logic signed [PC_W-1:0]  off_ext;
  assign off_s   = {field[IMM_W-1:0], {ALIGN_W{1'b0}}};
  assign off_ext = off_s;

  p_reset_start_r1: assert property (@(posedge clk)
    !rst_n |=> (pc_q == RESET_PC));

  p_hold_on_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc_q));

  p_load_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (pc_q == $past(next_pc)));

  p_fall_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_jump && !is_branch) |-> (next_pc == pc_q + STEP));

  p_branch_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && br_taken && !is_jump) |-> ((next_pc - seq_pc) == pc_t'(off_ext)));

  p_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !br_taken && !is_jump) |-> (next_pc == pc_q + STEP));

  p_taken_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !is_branch && !is_jump) |-> (src == SRC_SEQ));

  p_jump_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |-> (next_pc[PC_W-REGION_W-1:0] == {field, {ALIGN_W{1'b0}}}));

  p_jump_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && is_branch && br_taken) |-> (src == SRC_JUMP));

  p_jump_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |-> (next_pc[PC_W-1 -: REGION_W] == seq_pc[PC_W-1 -: REGION_W]));

  p_word_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q[ALIGN_W-1:0] == '0));

  p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q == ('1 << ALIGN_W) && !stall && src == SRC_SEQ) |=> (pc_q == '0));

endmodule

bind npc_gen npc_gen_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .is_branch (is_branch),
  .is_jump   (is_jump),
  .br_taken  (br_taken),
  .field     (instr[npc_pkg::JIDX_W-1:0]),
  .pc_q      (pc_q),
  .next_pc   (next_pc),
  .seq_pc    (seq_pc),
  .src       (src)
);

// File: tb/npc_gen_test.sv
module npc_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START  = 32'h0040_0000;
  localparam logic [31:0] HIGH_START = 32'hFFFF_FFF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] instr = '0;
  logic        is_branch = 1'b0;
  logic        is_jump = 1'b0;
  logic        br_taken = 1'b0;
  logic [31:0] pc_q, next_pc, hi_pc, hi_next;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] model_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_gen #(.RESET_PC(START)) uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
    .is_branch(is_branch), .is_jump(is_jump), .br_taken(br_taken),
    .pc_q(pc_q), .next_pc(next_pc)
  );

  npc_gen #(.RESET_PC(HIGH_START)) uut_high (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
    .is_branch(is_branch), .is_jump(is_jump), .br_taken(br_taken),
    .pc_q(hi_pc), .next_pc(hi_next)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Expected values restated with integer arithmetic.
  function automatic logic [31:0] want_branch(logic [31:0] pc, logic [15:0] imm);
    int disp;
    disp = int'($signed(imm)) * 4;
    return pc + 32'd4 + 32'(disp);
  endfunction

  function automatic logic [31:0] want_jump(logic [31:0] pc, logic [25:0] idx);
    return ((pc + 32'd4) & 32'hF000_0000) | (32'(idx) * 32'd4);
  endfunction

  task automatic drive(input logic b, input logic j, input logic t, input logic [31:0] w);
    is_branch = b; is_jump = j; br_taken = t; instr = w;
  endtask

  // Check the combinational result, take one edge, check the register.
  task automatic advance(input string tag, input logic [31:0] exp);
    #1;
    check({tag, " next_pc"}, next_pc, exp);
    @(posedge clk); #1;
    check({tag, " pc_q"}, pc_q, exp);
    check("R11 alignment", {30'd0, pc_q[1:0]}, 32'd0);
    model_pc = exp;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(0, 0, 0, '0);
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset value", pc_q, START);
    check("R1 reset value (high instance)", hi_pc, HIGH_START);
    rst_n = 1'b1;
    model_pc = START;
  endtask

  task automatic t_sequential;
    drive(0, 0, 0, 32'hDEAD_BEEF);
    advance("R3 sequential 1", model_pc + 32'd4);
    check("R12 high instance step", hi_pc, 32'hFFFF_FFFC);
    advance("R3 sequential 2", model_pc + 32'd4);
    check("R12 wrap to zero", hi_pc, 32'h0000_0000);
    advance("R3 sequential 3", model_pc + 32'd4);
    check("R3 absolute", model_pc, 32'h0040_000C);
  endtask

  task automatic t_stall;
    logic [31:0] held;
    held = model_pc;
    stall = 1'b1;
    drive(1, 0, 1, 32'h0000_0010);
    #1;
    check("R2 next_pc computed while stalled", next_pc, want_branch(held, 16'h0010));
    repeat (2) @(posedge clk);
    #1;
    check("R2 stall holds pc", pc_q, held);
    stall = 1'b0;
  endtask

  task automatic t_branch_forward;
    drive(1, 0, 1, {6'h04, 5'd3, 5'd7, 16'h0003});
    advance("R4 forward branch", want_branch(model_pc, 16'h0003));
    check("R4 forward absolute", model_pc, 32'h0040_001C);
  endtask

  task automatic t_branch_backward;
    drive(1, 0, 1, {6'h05, 5'd1, 5'd2, 16'hFFFE});
    advance("R5 backward branch", want_branch(model_pc, 16'hFFFE));
    check("R5 backward absolute", model_pc, 32'h0040_0018);
    drive(1, 0, 1, {6'h05, 5'd1, 5'd2, 16'h8000});
    advance("R5 most negative offset", want_branch(model_pc, 16'h8000));
    check("R5 most negative absolute", model_pc, 32'h003E_001C);
  endtask

  task automatic t_not_taken;
    drive(1, 0, 0, {6'h04, 5'd0, 5'd0, 16'h0100});
    advance("R6 not taken", model_pc + 32'd4);
    drive(0, 0, 1, {6'h00, 5'd0, 5'd0, 16'h0100});
    advance("R7 taken flag without branch", model_pc + 32'd4);
  endtask

  task automatic t_jump;
    drive(0, 1, 0, {6'h02, 26'h012_3456});
    advance("R8 jump", want_jump(model_pc, 26'h012_3456));
    check("R8 jump absolute", model_pc, 32'h0048_D158);
    drive(1, 1, 1, {6'h02, 26'h000_0040});
    advance("R9 jump beats taken branch", want_jump(model_pc, 26'h000_0040));
    check("R9 jump absolute", model_pc, 32'h0000_0100);
  endtask

  task automatic t_region_edge;
    drive(0, 1, 0, {6'h02, 26'h3FF_FFFF});
    advance("R10 reach region end", 32'h0FFF_FFFC);
    drive(0, 1, 0, {6'h02, 26'h000_0010});
    advance("R10 jump from last word", want_jump(model_pc, 26'h000_0010));
    check("R10 next region", model_pc, 32'h1000_0040);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequential();
    t_stall();
    t_branch_forward();
    t_branch_backward();
    t_not_taken();
    t_jump();
    t_region_edge();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule